// File: doc/BRIEF.md
# Redriver Link Power-Mode Controller

This block is the synchronous mode controller of a two-lane signal redriver. From a device enable pin, a compliance-test pin, per-lane far-end receiver sensing results, per-lane electrical-idle flags, per-lane low-frequency wake activity and a link-break indication, it decides whether the lanes sleep, search for a far-end receiver, pass data, rest in a deep link low-power state, or sit in compliance test mode.

It drives the receive and transmit termination controls, the transmitter high-impedance controls, a sensing request for the analog detect circuit, and two power-gating enables per lane: one for the full data path and one for the wake monitor. Every wait is counted in clock cycles set by a parameter: the sensing window, the retry period between failed searches, and the continuous-idle time that leads to the deep low-power state.

Top module: `rdrv_pwr_ctrl`

## Requirements
- R1: Out of reset, and whenever the block sleeps, both termination controls of every lane are 0, every `tx_hiz_o` bit is 1, and `ch_pwr_o`, `lfps_mon_o` and `det_pulse_o` are all 0. With `en_i` held low after reset the block stays asleep.
- R2: A high-to-low change of `en_i`, seen at one clock edge, puts the block to sleep at that edge from any mode, ahead of every other event.
- R3: While asleep, `en_i` high with `comp_i` low starts a search at the next edge. A search holds `det_pulse_o` at 1 for exactly `DET_CYC` cycles, with `rx_term_o` at 0 and every transmitter driven (`tx_hiz_o` bit 0).
- R4: At the last search cycle, if every bit of `rxdet_ok_i` is 1, the next cycle is active: `rx_term_o`, `tx_term_o`, `ch_pwr_o` and `lfps_mon_o` all 1 for each lane.
- R5: If any `rxdet_ok_i` bit is 0 at the last search cycle, the block waits `RETRY_CYC` cycles with terminations off and lanes unpowered; `tx_hiz_o` bit i is 1 exactly for each lane i whose result was 0. Then it searches again, endlessly until success or sleep.
- R6: `link_break_i` high in active or deep low-power mode starts a new search at the next edge.
- R7: With `en_i` and `comp_i` both high the block enters compliance mode at the next edge (from sleep or any awake mode): terminations 1, lanes powered, transmitters driven, wake monitor 0, and `det_pulse_o` stays 0 for as long as `comp_i` stays high.
- R8: Clearing `comp_i` while `en_i` stays high in compliance mode starts a search at the next edge.
- R9: In active mode, `tx_hiz_o` bit i equals `eidle_i` bit i in the same cycle.
- R10: In active mode, `IDLE_CYC` consecutive edges with every `eidle_i` bit at 1 move the block to deep low power: terminations stay 1, `ch_pwr_o` 0, `lfps_mon_o` 1, `tx_hiz_o` all 1. Any edge with an active lane restarts the count.
- R11: In deep low power, any `lfps_i` bit at 1 returns the block to active mode at the next edge.
- R12: When events coincide, the order is: enable fall, then compliance entry, then link break, then wake activity or idle expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Device enable; low means sleep |
| comp_i | input | 1 | Compliance test request |
| rxdet_ok_i | input | N_CH | Per-lane far-end receiver found, read at the last search cycle |
| eidle_i | input | N_CH | Per-lane receive electrical idle |
| lfps_i | input | N_CH | Per-lane low-frequency wake activity |
| link_break_i | input | 1 | Link lost (upstream disconnect) |
| rx_term_o | output | N_CH | Receive termination low impedance when 1 |
| tx_term_o | output | N_CH | Transmit termination nominal when 1 |
| tx_hiz_o | output | N_CH | Transmitter high impedance when 1 |
| det_pulse_o | output | 1 | Far-end receiver sensing request |
| ch_pwr_o | output | N_CH | Full data-path power enable per lane |
| lfps_mon_o | output | N_CH | Wake-monitor power enable per lane |

## Verification
The sharpest coincidence is a link break landing in the same cycle as wake activity in deep low power (or as the idle count expiring in active mode); the break must win and start a search rather than resume data. The same concern holds for an enable fall meeting compliance entry or a search result. These are provoked both by directed cycles that raise the two inputs together and by a long random run with rare, independent events, and each cycle's outputs are judged against a reference model in the bench that applies the R12 order.

// File: rtl/rdrv_pwr_pkg.sv
`timescale 1ns/1ps
package rdrv_pwr_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_DSENSE = 3'd1,
    ST_DWAIT  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_LOWPWR = 3'd4,
    ST_COMPLY = 3'd5
  } rdrv_st_e;

  // Width needed to count up to and including lim.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Linked modes keep the terminations on.
  function automatic logic is_linked(rdrv_st_e s);
    return (s == ST_ACTIVE) || (s == ST_LOWPWR) || (s == ST_COMPLY);
  endfunction

endpackage

// File: rtl/rdrv_pin_edge.sv
`timescale 1ns/1ps
module rdrv_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign fall_o = pin_q & ~pin_i;
endmodule

// File: rtl/rdrv_cyc_timer.sv
`timescale 1ns/1ps
module rdrv_cyc_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);
  localparam logic [TW-1:0] CNT_MAX = '1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // Fires on the last cycle of a window of lim_i cycles.
  assign hit_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/rdrv_idle_track.sv
`timescale 1ns/1ps
module rdrv_idle_track #(
  parameter int unsigned N_CH     = 2,
  parameter int unsigned IDLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic [N_CH-1:0] eidle_i,
  output logic            expire_o
);
  localparam int unsigned IW = rdrv_pwr_pkg::cnt_width(IDLE_CYC);
  localparam logic [IW-1:0] LAST = IW'(IDLE_CYC - 1);

  logic [IW-1:0] cnt_q;
  logic          all_idle;

  assign all_idle = &eidle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (arm_i && all_idle) begin
      if (cnt_q != IW'(IDLE_CYC))         cnt_q <= cnt_q + 1'b1;
    end else                              cnt_q <= '0;
  end

  assign expire_o = arm_i & all_idle & (cnt_q == LAST);
endmodule

// File: rtl/rdrv_chan_map.sv
`timescale 1ns/1ps
module rdrv_chan_map
  import rdrv_pwr_pkg::*;
(
  input  rdrv_st_e st_i,
  input  logic     eidle_i,
  input  logic     det_ok_i,
  output logic     rx_term_o,
  output logic     tx_term_o,
  output logic     tx_hiz_o,
  output logic     pwr_o,
  output logic     mon_o
);
  always_comb begin
    rx_term_o = is_linked(st_i);
    tx_term_o = is_linked(st_i);
    pwr_o     = (st_i == ST_ACTIVE) || (st_i == ST_COMPLY);
    mon_o     = (st_i == ST_ACTIVE) || (st_i == ST_LOWPWR);
    unique case (st_i)
      ST_DSENSE: tx_hiz_o = 1'b0;
      ST_DWAIT:  tx_hiz_o = ~det_ok_i;
      ST_ACTIVE: tx_hiz_o = eidle_i;
      ST_COMPLY: tx_hiz_o = 1'b0;
      default:   tx_hiz_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rdrv_pwr_ctrl.sv
`timescale 1ns/1ps
module rdrv_pwr_ctrl
  import rdrv_pwr_pkg::*;
#(
  parameter int unsigned N_CH      = 2,
  parameter int unsigned DET_CYC   = 100,
  parameter int unsigned RETRY_CYC = 1200000,
  parameter int unsigned IDLE_CYC  = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            comp_i,
  input  logic [N_CH-1:0] rxdet_ok_i,
  input  logic [N_CH-1:0] eidle_i,
  input  logic [N_CH-1:0] lfps_i,
  input  logic            link_break_i,
  output logic [N_CH-1:0] rx_term_o,
  output logic [N_CH-1:0] tx_term_o,
  output logic [N_CH-1:0] tx_hiz_o,
  output logic            det_pulse_o,
  output logic [N_CH-1:0] ch_pwr_o,
  output logic [N_CH-1:0] lfps_mon_o
);
  localparam int unsigned TW = cnt_width(max2(DET_CYC, RETRY_CYC));

  rdrv_st_e        state_q, state_d;
  logic [N_CH-1:0] det_ok_q;
  logic [TW-1:0]   tmr_lim;

  // Named internal events, also watched by the checker.
  logic en_fall;
  logic tmr_hit;
  logic idle_exp;
  logic sense_done;
  logic retry_due;
  logic wake_ev;
  logic state_chg;

  rdrv_pin_edge u_en_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (en_i),
    .fall_o (en_fall)
  );

  assign tmr_lim   = (state_q == ST_DSENSE) ? TW'(DET_CYC) : TW'(RETRY_CYC);
  assign state_chg = (state_d != state_q);

  rdrv_cyc_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (state_chg),
    .lim_i     (tmr_lim),
    .hit_o     (tmr_hit)
  );

  rdrv_idle_track #(.N_CH(N_CH), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (state_q == ST_ACTIVE),
    .eidle_i  (eidle_i),
    .expire_o (idle_exp)
  );

  assign sense_done = (state_q == ST_DSENSE) && tmr_hit;
  assign retry_due  = (state_q == ST_DWAIT) && tmr_hit;
  assign wake_ev    = (state_q == ST_LOWPWR) && (|lfps_i);

  always_comb begin
    state_d = state_q;
    if (en_fall) begin
      state_d = ST_SLEEP;
    end else if (state_q == ST_SLEEP) begin
      if (en_i) state_d = comp_i ? ST_COMPLY : ST_DSENSE;
    end else if (comp_i && (state_q != ST_COMPLY)) begin
      state_d = ST_COMPLY;
    end else begin
      unique case (state_q)
        ST_COMPLY: if (!comp_i) state_d = ST_DSENSE;
        ST_DSENSE: if (sense_done) state_d = (&rxdet_ok_i) ? ST_ACTIVE : ST_DWAIT;
        ST_DWAIT:  if (retry_due) state_d = ST_DSENSE;
        ST_ACTIVE: begin
          if (link_break_i)  state_d = ST_DSENSE;
          else if (idle_exp) state_d = ST_LOWPWR;
        end
        ST_LOWPWR: begin
          if (link_break_i) state_d = ST_DSENSE;
          else if (wake_ev) state_d = ST_ACTIVE;
        end
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SLEEP;
      det_ok_q <= '0;
    end else begin
      state_q <= state_d;
      if (sense_done) det_ok_q <= rxdet_ok_i;
    end
  end

  assign det_pulse_o = (state_q == ST_DSENSE);

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    rdrv_chan_map u_map (
      .st_i      (state_q),
      .eidle_i   (eidle_i[g]),
      .det_ok_i  (det_ok_q[g]),
      .rx_term_o (rx_term_o[g]),
      .tx_term_o (tx_term_o[g]),
      .tx_hiz_o  (tx_hiz_o[g]),
      .pwr_o     (ch_pwr_o[g]),
      .mon_o     (lfps_mon_o[g])
    );
  end
endmodule

// File: rtl/rdrv_pwr_ctrl_chk.sv
`timescale 1ns/1ps
module rdrv_pwr_ctrl_chk
  import rdrv_pwr_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            comp_i,
  input logic            link_break_i,
  input logic [N_CH-1:0] eidle_i,
  input logic [N_CH-1:0] rxdet_ok_i,
  input rdrv_st_e        state_q,
  input logic            sense_done,
  input logic            wake_ev,
  input logic [N_CH-1:0] rx_term_o,
  input logic [N_CH-1:0] tx_term_o,
  input logic [N_CH-1:0] tx_hiz_o,
  input logic            det_pulse_o,
  input logic [N_CH-1:0] ch_pwr_o
);
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SLEEP |-> (rx_term_o == '0) && (tx_term_o == '0) && (ch_pwr_o == '0) && (tx_hiz_o == '1)); // R1

  AST_FALL_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |=> state_q == ST_SLEEP); // R2

  AST_SENSE_NOTERM: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse_o |-> (rx_term_o == '0) && (tx_hiz_o == '0)); // R3

  AST_SENSE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    sense_done && (&rxdet_ok_i) && en_i && !comp_i |=> state_q == ST_ACTIVE); // R4

  AST_BREAK_RESEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE || state_q == ST_LOWPWR) && link_break_i && en_i && !comp_i |=> state_q == ST_DSENSE); // R6

  AST_COMPLY_NODET: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_COMPLY |-> !det_pulse_o && (rx_term_o == '1)); // R7

  AST_COMPLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_COMPLY && en_i && !comp_i |=> state_q == ST_DSENSE); // R8

  AST_ACTIVE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ACTIVE |-> tx_hiz_o == eidle_i); // R9

  AST_LFPS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev && !link_break_i && en_i && !comp_i |=> state_q == ST_ACTIVE); // R11
endmodule

bind rdrv_pwr_ctrl rdrv_pwr_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .comp_i       (comp_i),
  .link_break_i (link_break_i),
  .eidle_i      (eidle_i),
  .rxdet_ok_i   (rxdet_ok_i),
  .state_q      (state_q),
  .sense_done   (sense_done),
  .wake_ev      (wake_ev),
  .rx_term_o    (rx_term_o),
  .tx_term_o    (tx_term_o),
  .tx_hiz_o     (tx_hiz_o),
  .det_pulse_o  (det_pulse_o),
  .ch_pwr_o     (ch_pwr_o)
);

// File: tb/rdrv_pwr_ctrl_test.sv
`timescale 1ns/1ps
module rdrv_pwr_ctrl_test;
  localparam int DET   = 3;
  localparam int RETRY = 20;
  localparam int IDLE  = 8;

  // Bench's own mode codes.
  localparam int M_SLP = 0, M_SNS = 1, M_WAT = 2, M_ACT = 3, M_LOW = 4, M_CMP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, comp = 1'b0, brk = 1'b0;
  logic [1:0] rxok = 2'b00, eid = 2'b00, lfps = 2'b00;
  logic [1:0] rx_term, tx_term, tx_hiz, ch_pwr, mon;
  logic det;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_st = M_SLP, m_tmr = 0, m_idle = 0;
  logic m_enq = 1'b0;
  logic [1:0] m_ok = 2'b00;

  always #5 clk = ~clk;

  rdrv_pwr_ctrl #(.N_CH(2), .DET_CYC(DET), .RETRY_CYC(RETRY), .IDLE_CYC(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .comp_i(comp), .rxdet_ok_i(rxok),
    .eidle_i(eid), .lfps_i(lfps), .link_break_i(brk),
    .rx_term_o(rx_term), .tx_term_o(tx_term), .tx_hiz_o(tx_hiz),
    .det_pulse_o(det), .ch_pwr_o(ch_pwr), .lfps_mon_o(mon)
  );

  // Expected outputs {rx_term, tx_term, tx_hiz, ch_pwr, lfps_mon, det}.
  function automatic logic [10:0] expect_out(int s, logic [1:0] e, logic [1:0] ok);
    case (s)
      M_SNS:   return {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1};
      M_WAT:   return {2'b00, 2'b00, ~ok,   2'b00, 2'b00, 1'b0};
      M_ACT:   return {2'b11, 2'b11, e,     2'b11, 2'b11, 1'b0};
      M_LOW:   return {2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 1'b0};
      M_CMP:   return {2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 1'b0};
      default: return {2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0};
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      M_SNS: return "R3";
      M_WAT: return "R5";
      M_ACT: return "R9";
      M_LOW: return "R10";
      M_CMP: return "R7";
      default: return "R1";
    endcase
  endfunction

  // Reference model, ordered per R12.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = M_SLP; m_tmr = 0; m_idle = 0; m_enq = 1'b0; m_ok = 2'b00;
    end else begin
      int nx;
      bit win_end;
      win_end = (m_st == M_SNS) ? (m_tmr == DET - 1) : (m_tmr == RETRY - 1);
      nx = m_st;
      if (m_enq && !en) nx = M_SLP;
      else if (m_st == M_SLP) begin
        if (en) nx = comp ? M_CMP : M_SNS;
      end else if (comp && m_st != M_CMP) nx = M_CMP;
      else if (m_st == M_CMP) begin
        if (!comp) nx = M_SNS;
      end else if (m_st == M_SNS) begin
        if (win_end) nx = (rxok == 2'b11) ? M_ACT : M_WAT;
      end else if (m_st == M_WAT) begin
        if (win_end) nx = M_SNS;
      end else if (m_st == M_ACT) begin
        if (brk) nx = M_SNS;
        else if (eid == 2'b11 && m_idle == IDLE - 1) nx = M_LOW;
      end else if (m_st == M_LOW) begin
        if (brk) nx = M_SNS;
        else if (lfps != 2'b00) nx = M_ACT;
      end
      if (m_st == M_SNS && win_end) m_ok = rxok;
      m_idle = (m_st == M_ACT && eid == 2'b11) ? m_idle + 1 : 0;
      m_tmr = (nx != m_st) ? 0 : m_tmr + 1;
      m_enq = en;
      m_st = nx;
    end
  end

  task automatic chk(string req, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] act_vec();
    return {rx_term, tx_term, tx_hiz, ch_pwr, mon, det};
  endfunction

  // Advance one cycle and compare against the model.
  task automatic step();
    @(negedge clk);
    #1;
    chk(req_of(m_st), act_vec(), expect_out(m_st, eid, m_ok));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bit_chk(string req, logic act, logic exp);
    chk(req, {10'd0, act}, {10'd0, exp});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset with enable low keeps the block asleep
    steps(3);
    chk("R1", act_vec(), {2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0});

    // R3: enable rises -> search window of DET cycles
    en = 1'b1; rxok = 2'b11;
    for (int i = 0; i < DET; i++) begin
      step();
      bit_chk("R3", det, 1'b1);
    end
    // R4: both found -> active
    step();
    chk("R4", act_vec(), {2'b11, 2'b11, eid, 2'b11, 2'b11, 1'b0});

    // R9: transmitter mirrors idle per lane
    eid = 2'b01; #1; chk("R9", {9'd0, tx_hiz}, {9'd0, 2'b01});
    eid = 2'b10; #1; chk("R9", {9'd0, tx_hiz}, {9'd0, 2'b10});

    // R10: interrupted idle restarts the count, then full count enters low power
    eid = 2'b11; steps(IDLE - 2);
    eid = 2'b01; step();
    eid = 2'b11; steps(IDLE - 1);
    chk("R10", {9'd0, ch_pwr}, {9'd0, 2'b11});
    step();
    chk("R10", {9'd0, ch_pwr, mon}, {7'd0, 2'b00, 2'b11});

    // R11: wake activity returns to active
    lfps = 2'b10; step(); lfps = 2'b00;
    chk("R11", {9'd0, ch_pwr}, {9'd0, 2'b11});

    // R6: link break -> new search; R5: one lane missing -> retry
    brk = 1'b1; rxok = 2'b01; eid = 2'b00; step(); brk = 1'b0;
    bit_chk("R6", det, 1'b1);
    steps(DET);
    chk("R5", act_vec(), {2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 1'b0});
    steps(RETRY - 1);
    bit_chk("R5", det, 1'b0);
    step();
    bit_chk("R5", det, 1'b1);
    rxok = 2'b11; steps(DET + 1);

    // R7: compliance holds detect off; R8: clearing it searches again
    comp = 1'b1; step();
    chk("R7", act_vec(), {2'b11, 2'b11, 2'b00, 2'b11, 2'b00, 1'b0});
    for (int i = 0; i < 30; i++) begin
      step();
      bit_chk("R7", det, 1'b0);
    end
    comp = 1'b0; step();
    bit_chk("R8", det, 1'b1);
    steps(DET);

    // R12: break and wake in the same cycle of low power -> search wins
    eid = 2'b11; steps(IDLE + 1);
    brk = 1'b1; lfps = 2'b01; step(); brk = 1'b0; lfps = 2'b00;
    bit_chk("R12", det, 1'b1);
    // R12/R2: enable fall together with compliance request -> sleep
    en = 1'b0; comp = 1'b1; step();
    chk("R2", act_vec(), {2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0});
    comp = 1'b0; steps(2);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) == 0) en = ~en;
      if ($urandom_range(0, 299) == 0) comp = ~comp;
      rxok = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11;
      eid  = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b11;
      lfps = ($urandom_range(0, 19) == 0) ? 2'($urandom) : 2'b00;
      brk  = ($urandom_range(0, 39) == 0);
      step();
    end

    done = 1;
    finish_run();
  end
endmodule